// File: doc/BRIEF.md
# Two-Stage Blitter Raster-Operation Unit

This block is the pixel arithmetic core of a block-transfer engine. For every operand set it takes a target pixel and two source pixels, plus a 32-bit command word. It applies two raster operations in a chain. The first combines the target with the first source. The second combines that intermediate value with the second source. Each operation may complement either of its inputs. It then applies one function out of a set: constant, pass, bitwise logic, saturating add, saturating subtract, or a fractional multiply that scales a pixel up or down in brightness.

A transfer sequencer fetches the pixels and presents one operand set per cycle with `in_valid`. It receives the clamped result two cycles later, marked by `out_valid`. The command word also carries three image index fields that only the sequencer uses. This unit ignores them, along with the two spare top bits. Memory addressing and transparency tests stay in the sequencer.

Top module: `blit_rop_pipe`

## Requirements
- R1: Only command bits [29:24] (second opcode) and [23:18] (first opcode) affect the result; bits [31:30] and the index fields in bits [17:0] have no effect.
- R2: The first opcode uses `tgt_pix` as operand A and `src1_pix` as operand B; the second opcode uses the first result as A and `src2_pix` as B.
- R3: In each 6-bit opcode, bit 5 set replaces operand A with its bitwise complement, and bit 4 set does the same for operand B, before the function in bits [3:0] is applied.
- R4: Function 0000 gives all zeros, 0001 gives A, 0010 gives B, 0011 gives A AND B, 0100 gives A OR B, 0101 gives A XOR B, 1111 gives all ones.
- R5: Function 0110 gives A+B, clamped to the all-ones pixel value on overflow.
- R6: Function 0111 gives A-B, clamped to zero when B exceeds A.
- R7: Function 1000 gives the upper PIX_W bits of the 2*PIX_W-bit product A*B, i.e. A scaled by B/2^PIX_W.
- R8: Function codes 1001 to 1110 give operand A (after any complement).
- R9: An operand set accepted with `in_valid` high at a clock edge is presented on `out_pix` with `out_valid` high after exactly two clock edges. A new set may be accepted on every cycle, and `out_valid` is low in cycles that follow no accepted set.
- R10: While `rst_n` is low, `out_valid` is low. Operand sets still in flight when reset is asserted never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand set and command present this cycle |
| cmd | input | 32 | Packed blit command word |
| tgt_pix | input | PIX_W | Target pixel, operand A of the first opcode |
| src1_pix | input | PIX_W | First source pixel, operand B of the first opcode |
| src2_pix | input | PIX_W | Second source pixel, operand B of the second opcode |
| out_valid | output | 1 | Result present |
| out_pix | output | PIX_W | Clamped result pixel |

## Verification
The bench builds the unit with PIX_W = 4. At that width every one of the 64 opcodes can be applied to all 256 operand pairs at each stage. The first stage is swept with the second opcode fixed to pass A. The second stage is swept with the first opcode fixed to pass B. The saturation boundaries of add and subtract, the product truncation and each undefined code are therefore all hit. Randomly chained commands with random bubbles and random index bits then exercise the two-cycle timing and field independence, and a reset asserted with sets in flight checks that they are discarded.

// File: rtl/blit_rop_pkg.sv
package blit_rop_pkg;

  localparam int CMD_W   = 32;
  localparam int FIELD_W = 6;
  localparam int OP2_LSB = 24;
  localparam int OP1_LSB = 18;

  typedef enum logic [3:0] {
    FN_ZERO   = 4'h0,
    FN_PASS_A = 4'h1,
    FN_PASS_B = 4'h2,
    FN_AND    = 4'h3,
    FN_OR     = 4'h4,
    FN_XOR    = 4'h5,
    FN_ADD    = 4'h6,
    FN_SUB    = 4'h7,
    FN_MUL    = 4'h8,
    FN_ONES   = 4'hF
  } rop_fn_e;

  typedef struct packed {
    logic       inv_a;
    logic       inv_b;
    logic [3:0] fn;
  } rop_code_t;

endpackage

// File: rtl/blit_rst_sync.sv
module blit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic meta_d;

  always_comb meta_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= meta_d;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/blit_rop_alu.sv
module blit_rop_alu
  import blit_rop_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  rop_code_t          code,
  input  logic [PIX_W-1:0]   a_in,
  input  logic [PIX_W-1:0]   b_in,
  output logic [PIX_W-1:0]   res
);

  localparam int SUM_W  = PIX_W + 1;
  localparam int PROD_W = 2 * PIX_W;

  logic [PIX_W-1:0]  opa;
  logic [PIX_W-1:0]  opb;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  diff;
  logic [PROD_W-1:0] prod;

  // operand conditioning
  always_comb begin
    opa = code.inv_a ? ~a_in : a_in;
    opb = code.inv_b ? ~b_in : b_in;
  end

  // wide arithmetic kept one bit (or one word) above the pixel
  always_comb begin
    sum  = {1'b0, opa} + {1'b0, opb};
    diff = {1'b0, opa} - {1'b0, opb};
    prod = PROD_W'(opa) * PROD_W'(opb);
  end

  // function select with clamping back to the pixel width
  always_comb begin
    case (code.fn)
      FN_ZERO:   res = '0;
      FN_PASS_A: res = opa;
      FN_PASS_B: res = opb;
      FN_AND:    res = opa & opb;
      FN_OR:     res = opa | opb;
      FN_XOR:    res = opa ^ opb;
      FN_ADD:    res = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
      FN_SUB:    res = diff[PIX_W] ? {PIX_W{1'b0}} : diff[PIX_W-1:0];
      FN_MUL:    res = prod[PROD_W-1 -: PIX_W];
      FN_ONES:   res = {PIX_W{1'b1}};
      default:   res = opa;
    endcase
  end

endmodule

// File: rtl/blit_rop_stage.sv
module blit_rop_stage
  import blit_rop_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  rop_code_t        code,
  input  logic [PIX_W-1:0] a_pix,
  input  logic [PIX_W-1:0] b_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  logic [PIX_W-1:0] res_d;
  logic             valid_d;
  logic             load_en;

  blit_rop_alu #(.PIX_W(PIX_W)) u_alu (
    .code (code),
    .a_in (a_pix),
    .b_in (b_pix),
    .res  (res_d)
  );

  always_comb begin
    valid_d = in_valid;
    load_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) out_pix <= res_d;
  end

endmodule

// File: rtl/blit_rop_pipe.sv
module blit_rop_pipe
  import blit_rop_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      cmd,
  input  logic [PIX_W-1:0] tgt_pix,
  input  logic [PIX_W-1:0] src1_pix,
  input  logic [PIX_W-1:0] src2_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  logic             rst_sync_n;
  rop_code_t        first_code;
  rop_code_t        second_code_d;
  rop_code_t        second_code_q;
  logic [PIX_W-1:0] src2_q;
  logic             mid_valid;
  logic [PIX_W-1:0] mid_pix;
  logic             side_en;

  blit_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // command decode
  always_comb begin
    first_code    = rop_code_t'(cmd[OP1_LSB +: FIELD_W]);
    second_code_d = rop_code_t'(cmd[OP2_LSB +: FIELD_W]);
    side_en       = in_valid;
  end

  // second opcode and second source travel beside stage one
  always_ff @(posedge clk) begin
    if (side_en) begin
      second_code_q <= second_code_d;
      src2_q        <= src2_pix;
    end
  end

  blit_rop_stage #(.PIX_W(PIX_W)) u_stage_first (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .code      (first_code),
    .a_pix     (tgt_pix),
    .b_pix     (src1_pix),
    .out_valid (mid_valid),
    .out_pix   (mid_pix)
  );

  blit_rop_stage #(.PIX_W(PIX_W)) u_stage_second (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (mid_valid),
    .code      (second_code_q),
    .a_pix     (mid_pix),
    .b_pix     (src2_q),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

endmodule

// File: rtl/blit_rop_pipe_chk.sv
module blit_rop_pipe_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_s,
  input logic             in_valid,
  input logic [31:0]      cmd,
  input logic [PIX_W-1:0] tgt_pix,
  input logic [PIX_W-1:0] src1_pix,
  input logic [PIX_W-1:0] src2_pix,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);

  logic [1:0] arm_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)               arm_cnt <= 2'd0;
    else if (arm_cnt != 2'd2) arm_cnt <= arm_cnt + 2'd1;
  end

  always_comb armed = (arm_cnt == 2'd2);

  // R9: fixed two-edge latency of the valid strobe
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_s)
    armed |-> (out_valid == $past(in_valid, 2)));

  // R10: nothing leaves the block while reset is held
  p_idle_in_reset_r10: assert property (@(posedge clk)
    !rst_s |-> !out_valid);

  // R1: command word and operands are fully defined when offered
  p_known_inputs_r1: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid |-> !$isunknown({cmd, tgt_pix, src1_pix, src2_pix}));

  // R4: constant functions on the second stage
  p_ones_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && out_valid && $past(cmd[27:24], 2) == 4'hF) |-> (out_pix == {PIX_W{1'b1}}));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && out_valid && $past(cmd[27:24], 2) == 4'h0) |-> (out_pix == {PIX_W{1'b0}}));

  // R2: second stage takes the second source as operand B
  p_pass_b_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && out_valid && $past(cmd[28:24], 2) == 5'h02) |-> (out_pix == $past(src2_pix, 2)));

  // R7: a fractional scale never exceeds the factor operand
  p_mul_bound_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (armed && out_valid && $past(cmd[29:24], 2) == 6'h08) |-> (out_pix <= $past(src2_pix, 2)));

endmodule

bind blit_rop_pipe blit_rop_pipe_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_s     (rst_sync_n),
  .in_valid  (in_valid),
  .cmd       (cmd),
  .tgt_pix   (tgt_pix),
  .src1_pix  (src1_pix),
  .src2_pix  (src2_pix),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/test_blit_rop_pipe.sv
module test_blit_rop_pipe;

  localparam int PW   = 4;
  localparam int PMAX = (1 << PW) - 1;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   cmd;
  logic [PW-1:0] tgt_pix;
  logic [PW-1:0] src1_pix;
  logic [PW-1:0] src2_pix;
  logic          out_valid;
  logic [PW-1:0] out_pix;

  int    n_checks;
  int    n_bad;
  bit    finished;

  // bench-side pipeline model
  bit    v_d1, v_d2;
  int    e_d1, e_d2;
  string t_d1, t_d2;

  blit_rop_pipe #(.PIX_W(PW)) i_blit_rop_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cmd       (cmd),
    .tgt_pix   (tgt_pix),
    .src1_pix  (src1_pix),
    .src2_pix  (src2_pix),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_op(input int op, input int a, input int b);
    int x;
    int y;
    x = ((op & 32) != 0) ? (a ^ PMAX) : a;
    y = ((op & 16) != 0) ? (b ^ PMAX) : b;
    case (op & 15)
      0:       return 0;
      1:       return x;
      2:       return y;
      3:       return x & y;
      4:       return x | y;
      5:       return x ^ y;
      6:       return (x + y > PMAX) ? PMAX : x + y;
      7:       return (x < y) ? 0 : x - y;
      8:       return (x * y) >> PW;
      15:      return PMAX;
      default: return x;
    endcase
  endfunction

  function automatic string tag_of(input int op);
    int f;
    f = op & 15;
    if ((op & 48) != 0) return "R3";
    if (f == 6) return "R5";
    if (f == 7) return "R6";
    if (f == 8) return "R7";
    if (f >= 9 && f <= 14) return "R8";
    return "R4";
  endfunction

  function automatic logic [31:0] make_cmd(input int op2, input int op1);
    logic [31:0] c;
    c = $urandom;
    c[29:24] = 6'(op2);
    c[23:18] = 6'(op1);
    return c;
  endfunction

  task automatic check_out();
    n_checks++;
    if (out_valid !== v_d2) begin
      n_bad++;
      $display("FAIL R9: out_valid=%0b expected=%0b at %0t", out_valid, v_d2, $time);
    end else if (v_d2) begin
      n_checks++;
      if (int'(out_pix) != e_d2) begin
        n_bad++;
        $display("FAIL %s: out_pix=%0d expected=%0d at %0t", t_d2, out_pix, e_d2, $time);
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] c, input int t, input int s1,
                      input int s2, input string tg);
    @(negedge clk);
    check_out();
    in_valid = v;
    cmd      = c;
    tgt_pix  = PW'(t);
    src1_pix = PW'(s1);
    src2_pix = PW'(s2);
    v_d2 = v_d1; e_d2 = e_d1; t_d2 = t_d1;
    v_d1 = v;
    e_d1 = ref_op(int'(c[29:24]), ref_op(int'(c[23:18]), t, s1), s2);
    t_d1 = tg;
  endtask

  task automatic check_idle(input string tg);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b expected=0 at %0t", tg, out_valid, $time);
    end
  endtask

  // watchdog
  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_bad = 0; finished = 0;
    v_d1 = 0; v_d2 = 0; e_d1 = 0; e_d2 = 0; t_d1 = "R9"; t_d2 = "R9";
    rst_n = 1'b0; in_valid = 1'b0; cmd = '0;
    tgt_pix = '0; src1_pix = '0; src2_pix = '0;

    // R10: output quiet while reset held
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_idle("R10");
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, '0, 0, 0, 0, "R9");

    // Stage one sweep, second opcode passes A (R2..R8)
    for (int op = 0; op < 64; op++)
      for (int t = 0; t <= PMAX; t++)
        for (int s = 0; s <= PMAX; s++)
          step(1'b1, make_cmd(6'h01, op), t, s, int'($urandom_range(0, PMAX)), tag_of(op));

    // Stage two sweep, first opcode passes B so the first result is src1 (R2)
    for (int op = 0; op < 64; op++)
      for (int a = 0; a <= PMAX; a++)
        for (int s = 0; s <= PMAX; s++)
          step(1'b1, make_cmd(op, 6'h02), int'($urandom_range(0, PMAX)), a, s,
               (op == 2) ? "R2" : tag_of(op));

    // R1: identical opcodes and operands, random index and spare bits
    for (int i = 0; i < 64; i++)
      step(1'b1, make_cmd(6'h06, 6'h28), 9, 5, 12, "R1");

    // R9: random chains with bubbles
    for (int i = 0; i < 3000; i++)
      step(bit'($urandom_range(0, 1)),
           make_cmd(int'($urandom_range(0, 63)), int'($urandom_range(0, 63))),
           int'($urandom_range(0, PMAX)), int'($urandom_range(0, PMAX)),
           int'($urandom_range(0, PMAX)), "R9");

    // R10: reset with sets in flight
    step(1'b1, make_cmd(6'h0F, 6'h0F), 1, 2, 3, "R10");
    step(1'b1, make_cmd(6'h0F, 6'h0F), 1, 2, 3, "R10");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R10");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_idle("R10");
    end
    in_valid = 1'b0;
    v_d1 = 0; v_d2 = 0;
    @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, '0, 0, 0, 0, "R10");
    for (int i = 0; i < 8; i++)
      step(1'b1, make_cmd(6'h07, 6'h06), 15, 15, int'($urandom_range(0, PMAX)), "R6");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 0, 0, 0, "R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule